// File: doc/BRIEF.md
# Real-Time Step Attenuator Controller

This block drives one step attenuator setting to every receive channel of a converter tile. Fabric logic presents a 5-bit attenuation code and an update strobe, both in the control clock domain. On an accepted rising edge of the strobe, the controller samples the code and checks it. It converts a valid code into decibels. After a fixed number of clock cycles, it applies the new value to all channel outputs on the same edge. A one-cycle valid pulse marks that edge.

Some cases are handled apart from the strobe path:

- On the first clock after reset, the controller takes the live code directly, with no strobe.
- A configuration input can disable the real-time interface. While it is low, every channel is forced to 0 dB.
- Strobe edges count only while the power-up status input reports done.
- An invalid code is never applied. It raises a sticky error flag instead.

If a new edge arrives while an earlier setting is still waiting out its latency, the new setting replaces the waiting one. The latency count starts again from the new edge.

Top module: `rt_atten_ctrl`

## Requirements
- R1: The attenuation in dB equals RANGE_DB minus code times STEP_DB. With the defaults (RANGE_DB = 27, STEP_DB = 1), code 17 gives 10 dB and code 0 gives 27 dB.
- R2: A code above MAX_CODE = RANGE_DB / STEP_DB (27 by default) is rejected on an edge. The current attenuation and any pending setting are left unchanged.
- R3: A capture happens only when update_in is sampled high on a clock edge after being sampled low on the previous one. The code is sampled on that same edge. Holding update_in high causes no further captures, and code changes during that time have no effect.
- R4: Rising edges of update_in that are sampled while pwr_done is low are ignored.
- R5: On the first clock edge after rst is released, code_in is applied directly if it is valid. The outputs and a valid pulse appear on the next cycle.
- R6: While rt_enable is low, every channel output reads 0 dB one cycle later. When rt_enable is raised again, the last applied value returns one cycle later.
- R7: An accepted edge sampled on clock edge n changes the outputs at clock edge n + LATENCY. atten_valid is high for exactly that one cycle.
- R8: All NUM_CH channel fields of atten_db, with channel i at bits [i*DB_W +: DB_W], always hold the same value.
- R9: code_err becomes 1 on the cycle after an invalid code is seen, either on an accepted edge or at the first clock after reset. It stays 1 until rst.
- R10: A valid edge that arrives while a setting is pending replaces that setting and restarts the latency count. If the new edge falls on the same edge where the old setting completes, the old setting is applied first and the new one LATENCY cycles later.
- R11: While rst is high, atten_db is 0, atten_valid is 0 and code_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_enable | input | 1 | Real-time interface enable; low forces 0 dB |
| pwr_done | input | 1 | Power-up sequence done status |
| code_in | input | CODE_W | Attenuation code from fabric |
| update_in | input | 1 | Update strobe; acts on its rising edge |
| atten_db | output | NUM_CH*DB_W | Per-channel attenuation in dB, channel i at [i*DB_W +: DB_W] |
| atten_valid | output | 1 | One-cycle pulse when a new setting is applied |
| code_err | output | 1 | Sticky flag for a rejected code |

## Verification
The delicate coincidence is a pending setting completing its latency on the same clock edge that a new strobe edge is accepted. The bench provokes it by raising the second strobe exactly LATENCY cycles after the first. It then judges the result against a queue-based model that applies the first value at that edge and the second value LATENCY cycles later. A second overlap places an invalid code edge inside a pending window. The model expects the error flag to rise while the pending value still lands on time.

// File: rtl/rtac_pkg.sv
package rtac_pkg;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_BOOT = 2'd1,
    SRC_FIRE = 2'd2
  } apply_src_e;

  function automatic int code_to_db(input int range_db, input int step_db, input int code);
    return range_db - code * step_db;
  endfunction

endpackage

// File: rtl/rtac_capture.sv
module rtac_capture
  import rtac_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int RANGE_DB = 27,
  parameter int STEP_DB  = 1,
  parameter int MAX_CODE = 27,
  parameter int DB_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_done,
  input  logic              update_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              boot_stb,
  output logic              boot_ok,
  output logic              acc_stb,
  output logic              bad_stb,
  output logic [DB_W-1:0]   cap_db
);

  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

  logic upd_q;
  logic init_q;
  logic code_ok;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q  <= 1'b0;
      init_q <= 1'b1;
    end else begin
      upd_q  <= update_in;
      init_q <= 1'b0;
    end
  end

  always_comb begin
    code_ok  = (code_in <= MAX_C);
    rise     = update_in & ~upd_q & ~init_q & pwr_done;
    boot_stb = init_q;
    boot_ok  = init_q & code_ok;
    acc_stb  = rise & code_ok;
    bad_stb  = (init_q | rise) & ~code_ok;
    cap_db   = DB_W'(code_to_db(RANGE_DB, STEP_DB, int'(code_in)));
  end

endmodule

// File: rtl/rtac_delay.sv
module rtac_delay #(
  parameter int DB_W    = 5,
  parameter int LATENCY = 220
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DB_W-1:0] load_db,
  output logic            fire,
  output logic [DB_W-1:0] fire_db
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [DB_W-1:0]  pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (load) begin
      cnt_q  <= LAT_C;
      pend_q <= load_db;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - ONE_C;
    end
  end

  assign fire    = (cnt_q == ONE_C);
  assign fire_db = pend_q;

endmodule

// File: rtl/rtac_fanout.sv
module rtac_fanout
  import rtac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DB_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic                   boot_ok,
  input  logic [DB_W-1:0]        boot_db,
  input  logic                   fire,
  input  logic [DB_W-1:0]        fire_db,
  output logic [NUM_CH*DB_W-1:0] atten_db,
  output logic                   valid
);

  apply_src_e      src;
  logic [DB_W-1:0] held_q;
  logic [DB_W-1:0] next_db;
  logic            valid_q;

  always_comb begin
    if (boot_ok)   src = SRC_BOOT;
    else if (fire) src = SRC_FIRE;
    else           src = SRC_HOLD;
    case (src)
      SRC_BOOT: next_db = boot_db;
      SRC_FIRE: next_db = fire_db;
      default:  next_db = held_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      held_q  <= next_db;
      valid_q <= (src != SRC_HOLD);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DB_W-1:0] ch_q;
    always_ff @(posedge clk) begin
      if (rst)         ch_q <= '0;
      else if (enable) ch_q <= next_db;
      else             ch_q <= '0;
    end
    assign atten_db[i*DB_W +: DB_W] = ch_q;
  end

  assign valid = valid_q;

endmodule

// File: rtl/rt_atten_ctrl.sv
module rt_atten_ctrl #(
  parameter int CODE_W   = 5,
  parameter int NUM_CH   = 4,
  parameter int RANGE_DB = 27,
  parameter int STEP_DB  = 1,
  parameter int LATENCY  = 220,
  parameter int DB_W     = $clog2(RANGE_DB + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rt_enable,
  input  logic                   pwr_done,
  input  logic [CODE_W-1:0]      code_in,
  input  logic                   update_in,
  output logic [NUM_CH*DB_W-1:0] atten_db,
  output logic                   atten_valid,
  output logic                   code_err
);

  localparam int MAX_CODE = RANGE_DB / STEP_DB;

  logic            boot_stb;
  logic            boot_ok;
  logic            acc_stb;
  logic            bad_stb;
  logic [DB_W-1:0] cap_db;
  logic            fire;
  logic [DB_W-1:0] fire_db;
  logic            err_q;

  rtac_capture #(
    .CODE_W(CODE_W), .RANGE_DB(RANGE_DB), .STEP_DB(STEP_DB),
    .MAX_CODE(MAX_CODE), .DB_W(DB_W)
  ) u_cap (
    .clk(clk), .rst(rst), .pwr_done(pwr_done), .update_in(update_in),
    .code_in(code_in), .boot_stb(boot_stb), .boot_ok(boot_ok),
    .acc_stb(acc_stb), .bad_stb(bad_stb), .cap_db(cap_db)
  );

  rtac_delay #(.DB_W(DB_W), .LATENCY(LATENCY)) u_dly (
    .clk(clk), .rst(rst), .load(acc_stb), .load_db(cap_db),
    .fire(fire), .fire_db(fire_db)
  );

  rtac_fanout #(.NUM_CH(NUM_CH), .DB_W(DB_W)) u_fan (
    .clk(clk), .rst(rst), .enable(rt_enable), .boot_ok(boot_ok),
    .boot_db(cap_db), .fire(fire & ~boot_stb), .fire_db(fire_db),
    .atten_db(atten_db), .valid(atten_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (bad_stb) err_q <= 1'b1;
  end

  assign code_err = err_q;

endmodule

// File: rtl/rtac_checks.sv
module rtac_checks #(
  parameter int NUM_CH   = 4,
  parameter int DB_W     = 5,
  parameter int RANGE_DB = 27
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rt_enable,
  input logic [NUM_CH*DB_W-1:0] atten_db,
  input logic                   atten_valid,
  input logic                   code_err
);

  localparam logic [DB_W-1:0] RANGE_C = DB_W'(RANGE_DB);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err);

  assert_force_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !rt_enable |=> (atten_db == '0));

  assert_lanes_equal_R8: assert property (@(posedge clk) disable iff (rst)
    atten_db == {NUM_CH{atten_db[DB_W-1:0]}});

  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    atten_db[DB_W-1:0] <= RANGE_C);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    atten_valid |=> !atten_valid);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(rt_enable) && $past(rt_enable, 2) && !atten_valid) |-> $stable(atten_db));

endmodule

bind rt_atten_ctrl rtac_checks #(.NUM_CH(NUM_CH), .DB_W(DB_W), .RANGE_DB(RANGE_DB)) u_chk (
  .clk(clk), .rst(rst), .rt_enable(rt_enable), .atten_db(atten_db),
  .atten_valid(atten_valid), .code_err(code_err)
);

// File: tb/rt_atten_ctrl_tb.sv
module rt_atten_ctrl_tb;

  localparam int NCH = 4;
  localparam int DBW = 5;
  localparam int LAT = 220;
  localparam int RNG = 27;
  localparam int STP = 1;
  localparam int MAXC = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic pwr = 1'b0;
  logic [4:0] code = 5'd5;
  logic upd = 1'b0;
  logic [NCH*DBW-1:0] atten;
  logic valid;
  logic err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R11";

  typedef struct { int t; int db; } ev_t;
  ev_t evq[$];
  int m_held, m_out, m_valid, m_err, m_prev;
  bit m_init;

  always #2 clk = ~clk;

  rt_atten_ctrl #(.NUM_CH(NCH), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .rt_enable(en), .pwr_done(pwr), .code_in(code),
    .update_in(upd), .atten_db(atten), .atten_valid(valid), .code_err(err)
  );

  // Behavioural reference model (R1..R11), advanced on each rising edge.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_held = 0; m_out = 0; m_valid = 0; m_err = 0; m_prev = 0; m_init = 1;
      evq.delete();
    end else begin
      m_valid = 0;
      if (m_init) begin
        m_init = 0;
        if (code <= MAXC) begin m_held = RNG - code * STP; m_valid = 1; end
        else m_err = 1;
      end else begin
        if (evq.size() > 0 && evq[0].t == cyc) begin
          m_held = evq[0].db; m_valid = 1; void'(evq.pop_front());
        end
        if (upd && !m_prev && pwr) begin
          if (code <= MAXC) begin
            evq.delete();
            evq.push_back('{t: cyc + LAT, db: RNG - code * STP});
          end else m_err = 1;
        end
      end
      m_prev = upd;
      m_out = en ? m_held : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (cyc > 0) begin
      for (int i = 0; i < NCH; i++)
        chk((i == 0) ? cur_req : "R8", int'(atten[i*DBW +: DBW]), m_out);
      chk(cur_req, int'(valid), m_valid);
      chk((cur_req == "R11") ? "R11" : "R9", int'(err), m_err);
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog at cycle %0d: actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int c);
    code = 5'(c);
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
  endtask

  initial begin
    // R11: reset state
    wait_n(3);
    chk("R11", int'(atten), 0);
    chk("R11", int'(valid), 0);
    chk("R11", int'(err), 0);
    // R5: boot load of code 5 -> 22 dB
    cur_req = "R5";
    rst = 1'b0;
    wait_n(2);
    chk("R5", int'(atten[DBW-1:0]), 22);
    // R4: edge with power-up not done is ignored
    cur_req = "R4";
    strobe(17);
    wait_n(LAT + 5);
    chk("R4", int'(atten[DBW-1:0]), 22);
    // R1, R3, R7: code 17 -> 10 dB, trigger held high, code changed while high
    pwr = 1'b1;
    cur_req = "R3";
    code = 5'd17;
    @(negedge clk) upd = 1'b1;
    @(negedge clk) code = 5'd3;
    wait_n(LAT + 20);
    chk("R1", int'(atten[DBW-1:0]), 10);
    upd = 1'b0;
    wait_n(LAT + 5);
    chk("R3", int'(atten[DBW-1:0]), 10);
    // R7: code 0 -> 27 dB latency, checked per cycle
    cur_req = "R7";
    strobe(0);
    wait_n(LAT + 5);
    chk("R7", int'(atten[DBW-1:0]), 27);
    // R2, R9: invalid code 30 ignored, error sticky
    cur_req = "R2";
    strobe(30);
    wait_n(LAT + 5);
    chk("R2", int'(atten[DBW-1:0]), 27);
    chk("R9", int'(err), 1);
    // R10: replacement during pending, plus invalid edge inside window
    cur_req = "R10";
    strobe(4);
    wait_n(40);
    strobe(31);
    wait_n(20);
    strobe(27);
    wait_n(LAT + 5);
    chk("R10", int'(atten[DBW-1:0]), 0);
    // R10: new edge exactly on completion of pending setting
    code = 5'd10;
    @(negedge clk) upd = 1'b1;
    @(negedge clk) begin upd = 1'b0; code = 5'd20; end
    wait_n(LAT - 2);
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
    chk("R10", int'(atten[DBW-1:0]), 17);
    wait_n(LAT + 5);
    chk("R10", int'(atten[DBW-1:0]), 7);
    // R6: disable forces 0 dB, update while disabled, re-enable
    cur_req = "R6";
    en = 1'b0;
    wait_n(2);
    chk("R6", int'(atten), 0);
    strobe(12);
    wait_n(LAT + 5);
    chk("R6", int'(atten), 0);
    en = 1'b1;
    wait_n(2);
    chk("R6", int'(atten[DBW-1:0]), 15);
    // R9, R5: invalid code at reset release
    cur_req = "R11";
    rst = 1'b1;
    code = 5'd31;
    wait_n(3);
    chk("R11", int'(err), 0);
    cur_req = "R9";
    rst = 1'b0;
    wait_n(3);
    chk("R9", int'(err), 1);
    chk("R5", int'(atten[DBW-1:0]), 0);
    wait_n(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule